// File: doc/BRIEF.md
# Converter Serial Port with Ready Signalling

This block is the slave-side serial port of a delta-sigma converter. A host reaches a small register file through a clocked serial link. One output pin does two jobs. While a register is being shifted out, it carries serial read data. At other times it carries an active-low flag that says a new conversion result is waiting. Conversion results come from the converter core on a one-cycle strobe with a parallel word. The port captures each result into a data register and raises the ready indication. Four general-purpose outputs follow a control register.

Every frame begins with an 8-bit command byte. The byte selects a register and says whether the access is a read or a write. The selected register's data follows. The link clock idles high. Input bits are taken on its rising edge and output bits change on its falling edge. The chip select may be toggled around frames (4-wire use) or tied low, in which case frames are delimited by bit counting alone (3-wire use). A continuous-read mode lets the host collect each new result by applying 24 clocks with no command byte, until a specific exit byte is sent.

The serial inputs are synchronised into the block clock domain. The protocol state machine has five states:
- `ST_CMD` collects the command byte.
- `ST_WR` collects write data.
- `ST_RD` shifts a register out.
- `ST_CRD_WAIT` is the idle state of continuous read.
- `ST_CRD_XFER` shifts a result out in continuous read.

The transitions are:
- `ST_CMD`→`ST_WR` on a write command.
- `ST_CMD`→`ST_RD` on a read command.
- `ST_CMD`→`ST_CRD_WAIT` on the continuous-read command.
- `ST_WR`→`ST_CMD` and `ST_RD`→`ST_CMD` when the last bit has been moved.
- `ST_CRD_WAIT`→`ST_CRD_XFER` on the first falling clock edge while a result is ready.
- `ST_CRD_XFER`→`ST_CRD_WAIT` after 24 bits.
- `ST_CRD_XFER`→`ST_CMD` after 24 bits if the exit byte arrived during the word.
- `ST_CRD_WAIT`→`ST_CMD` on the exit byte.
- Any state→`ST_CMD` on chip-select release, except the continuous-read states, which go to `ST_CRD_WAIT`.

Top module: `conv_serial_port`

## Requirements
- R1: Each frame starts with an 8-bit command byte, taken MSB first on rising `sclk` edges. The bit fields are:
  - Bit 7 must be 0; a byte with bit 7 set is ignored, and the next byte is treated as a command.
  - Bit 6 selects the direction: 1 means read, 0 means write.
  - Bits 5:3 give the address: 0 status, 1 mode, 3 data, 5 GPIO.
  - Bit 2 requests continuous read.

  The status register reads with bit 7 equal to the active-low ready flag and bits 6:0 equal to zero.
- R2: After reset, the ready flag is 1. A `res_valid` strobe loads `res_data` into the data register and clears the ready flag to 0. While `cs_n` is low outside a read shift, `dout_rdy` equals the ready flag.
- R3: Read data leaves MSB first on `dout_rdy`, changing on falling `sclk` edges. The status, mode and GPIO registers are 8 bits wide; the data register is 24 bits wide.
- R4: Once all 24 bits of the data register have been read, the ready flag and `dout_rdy` return to 1. A further data read outside continuous read returns the same word.
- R5: The mode register and the GPIO register are written by a write command followed by 8 data bits. Both read back as written and both reset to 0. `mode_cfg` shows the mode register. `gpo[3:0]` shows GPIO register bits 3:0.
- R6: A result that arrives while the data register is being shifted out does not change the word in flight. It is loaded, and the ready flag is cleared, once the shift ends.
- R7: Raising `cs_n` aborts any transfer and clears the bit count, so the next frame starts with a command byte. While `cs_n` is high, `dout_rdy` is 1.
- R8: The command 8'h5C enters continuous read. Each time a result is ready, 24 falling `sclk` edges shift it out with no command byte.
- R9: In continuous read, a result can be read only once. After that, `dout_rdy` stays 1 and further clocks return all ones until the next result arrives.
- R10: In continuous read, the byte 8'h58 on `din` leaves the mode. The next byte is then taken as a command.
- R11: With `cs_n` held low throughout (3-wire use), consecutive frames are separated by bit count alone, and all of the above still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host, idle high |
| cs_n | input | 1 | Active-low chip select, may be tied low |
| din | input | 1 | Serial data from host |
| dout_rdy | output | 1 | Serial read data, or the active-low ready flag |
| res_valid | input | 1 | One-cycle strobe that delivers a conversion result |
| res_data | input | 24 | Conversion result word |
| gpo | output | 4 | General-purpose outputs from GPIO register bits 3:0 |
| mode_cfg | output | 8 | Contents of the mode register |

## Verification
Two functions can fall in the same cycle:
- A conversion-result strobe can arrive while the data word is being shifted out.
- The end-of-word consumption, which sets the ready flag, can be immediately followed by the load of a deferred result, which clears it.

The bench provokes this by pausing the serial clock partway through a data read and pulsing the result strobe. It then finishes the word. It judges three things: the word received must be the old one, `dout_rdy` must fall shortly after the last bit, and a second read must return the new result.

// File: rtl/cspi_pkg.sv
package cspi_pkg;

    localparam int CMD_W = 8;

    typedef enum logic [2:0] {
        ST_CMD      = 3'd0,
        ST_WR       = 3'd1,
        ST_RD       = 3'd2,
        ST_CRD_WAIT = 3'd3,
        ST_CRD_XFER = 3'd4
    } cspi_state_e;

    localparam logic [2:0] A_STAT = 3'd0;
    localparam logic [2:0] A_MODE = 3'd1;
    localparam logic [2:0] A_DATA = 3'd3;
    localparam logic [2:0] A_GPIO = 3'd5;

    localparam logic [CMD_W-1:0] EXIT_CMD = 8'h58;

endpackage

// File: rtl/cspi_sync.sv
module cspi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic din,
    output logic cs_n_s,
    output logic din_s,
    output logic sclk_rise,
    output logic sclk_fall
);
    localparam int W = 3;
    localparam logic [W-1:0] RST_V = 3'b110;

    logic [W-1:0] raw;
    logic [W-1:0] last;
    logic         sclk_d;

    assign raw = {sclk, cs_n, din};

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [W-1:0] q;
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) q <= RST_V;
                    else        q <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) q <= RST_V;
                    else        q <= g_stage[g-1].q;
                end
            end
        end
    endgenerate

    assign last = g_stage[STAGES-1].q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= last[2];
    end

    assign cs_n_s    = last[1];
    assign din_s     = last[0];
    assign sclk_rise = last[2] & ~sclk_d;
    assign sclk_fall = ~last[2] & sclk_d;

endmodule

// File: rtl/cspi_regs.sv
module cspi_regs
    import cspi_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int REG_W  = 8,
    parameter int GPO_N  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [2:0]        rd_addr,
    input  logic              busy,
    input  logic              consume,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    output logic [DATA_W-1:0] rd_value,
    output logic              rdy_n,
    output logic [GPO_N-1:0]  gpo,
    output logic [REG_W-1:0]  mode_q
);
    localparam int PAD = DATA_W - REG_W;

    logic [REG_W-1:0]  gpio_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] pend_d;
    logic              pend_v;
    logic              load;
    logic [DATA_W-1:0] load_val;

    assign load     = !busy && (res_valid || pend_v);
    assign load_val = res_valid ? res_data : pend_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            gpio_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_MODE) mode_q <= wr_data;
            if (wr_addr == A_GPIO) gpio_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            pend_d <= '0;
            pend_v <= 1'b0;
            rdy_n  <= 1'b1;
        end else begin
            if (consume) rdy_n <= 1'b1;
            if (load) begin
                data_q <= load_val;
                pend_v <= 1'b0;
                rdy_n  <= 1'b0;
            end else if (busy && res_valid) begin
                pend_d <= res_data;
                pend_v <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_STAT:  rd_value = {{PAD{1'b0}}, rdy_n, {(REG_W-1){1'b0}}};
            A_MODE:  rd_value = {{PAD{1'b0}}, mode_q};
            A_DATA:  rd_value = data_q;
            A_GPIO:  rd_value = {{PAD{1'b0}}, gpio_q};
            default: rd_value = '0;
        endcase
    end

    assign gpo = gpio_q[GPO_N-1:0];

    // data word must not change under a shift that started earlier (R6)
    assert_holdoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(data_q));

    // ready only asserts after a result was presented (R2)
    assert_rdy_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(res_valid || pend_v));

    // outputs move only on a GPIO write (R5)
    assert_gpo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_GPIO) |=> $stable(gpo));

endmodule

// File: rtl/cspi_fsm.sv
module cspi_fsm
    import cspi_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              din_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic [DATA_W-1:0] rd_value,
    input  logic              rdy_n,
    output logic [2:0]        rd_addr,
    output logic              wr_en,
    output logic [2:0]        wr_addr,
    output logic [REG_W-1:0]  wr_data,
    output logic              busy,
    output logic              consume,
    output logic              pin
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] LAST_REG  = CNT_W'(REG_W - 1);
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(DATA_W - 1);
    localparam int ALIGN = DATA_W - REG_W;

    cspi_state_e st, st_n;

    logic [CNT_W-1:0]  cnt;
    logic [CMD_W-1:0]  cmd_sh;
    logic [CMD_W-1:0]  cmd_next;
    logic [2:0]        addr_q;
    logic [DATA_W-1:0] sh;
    logic              dout_q;
    logic              exit_pend;
    logic [CNT_W-1:0]  last_bit;
    logic [CNT_W-1:0]  limit;
    logic              cmd_done;

    assign cmd_next = {cmd_sh[CMD_W-2:0], din_s};
    assign last_bit = (addr_q == A_DATA) ? LAST_WORD : LAST_REG;
    assign cmd_done = sclk_rise && (cnt == LAST_CMD);

    always_comb begin
        unique case (st)
            ST_RD:       limit = last_bit;
            ST_CRD_XFER: limit = LAST_WORD;
            default:     limit = LAST_CMD;
        endcase
    end

    // next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            ST_CMD: begin
                if (cmd_done && !cmd_next[7]) begin
                    if (!cmd_next[6])                                st_n = ST_WR;
                    else if (cmd_next[2] && cmd_next[5:3] == A_DATA) st_n = ST_CRD_WAIT;
                    else                                             st_n = ST_RD;
                end
            end
            ST_WR: if (cmd_done) st_n = ST_CMD;
            ST_RD: if (sclk_rise && cnt == last_bit) st_n = ST_CMD;
            ST_CRD_WAIT: begin
                if (sclk_fall && !rdy_n && cnt == '0)      st_n = ST_CRD_XFER;
                else if (cmd_done && cmd_next == EXIT_CMD) st_n = ST_CMD;
            end
            ST_CRD_XFER: begin
                if (sclk_rise && cnt == LAST_WORD)
                    st_n = exit_pend ? ST_CMD : ST_CRD_WAIT;
            end
            default: st_n = ST_CMD;
        endcase
        if (cs_n_s) begin
            st_n = (st == ST_CRD_WAIT || st == ST_CRD_XFER) ? ST_CRD_WAIT : ST_CMD;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_CMD;
        else        st <= st_n;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            cmd_sh    <= '0;
            addr_q    <= A_STAT;
            sh        <= '0;
            dout_q    <= 1'b1;
            exit_pend <= 1'b0;
        end else if (cs_n_s) begin
            cnt       <= '0;
            cmd_sh    <= '0;
            exit_pend <= 1'b0;
        end else begin
            if (sclk_rise) begin
                cnt    <= (cnt == limit) ? '0 : cnt + 1'b1;
                cmd_sh <= cmd_next;
                if (st == ST_CMD && cmd_done && !cmd_next[7]) addr_q <= cmd_next[5:3];
                if (st == ST_CMD && st_n == ST_RD) begin
                    sh <= (cmd_next[5:3] == A_DATA) ? rd_value : (rd_value << ALIGN);
                end
                if (st == ST_CRD_XFER && cnt == LAST_CMD && cmd_next == EXIT_CMD) exit_pend <= 1'b1;
                if (st == ST_CRD_XFER && cnt == LAST_WORD) exit_pend <= 1'b0;
            end
            if (sclk_fall) begin
                if (st == ST_RD || st == ST_CRD_XFER) begin
                    dout_q <= sh[DATA_W-1];
                    sh     <= sh << 1;
                end else if (st == ST_CRD_WAIT && st_n == ST_CRD_XFER) begin
                    dout_q <= rd_value[DATA_W-1];
                    sh     <= rd_value << 1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        rd_addr = (st == ST_CRD_WAIT || st == ST_CRD_XFER) ? A_DATA : cmd_next[5:3];
        wr_en   = (st == ST_WR) && cmd_done && !cs_n_s;
        wr_addr = addr_q;
        wr_data = cmd_next[REG_W-1:0];
        busy    = (st == ST_RD && addr_q == A_DATA) || (st == ST_CRD_XFER);
        consume = !cs_n_s && sclk_rise &&
                  ((st == ST_RD && addr_q == A_DATA && cnt == LAST_WORD) ||
                   (st == ST_CRD_XFER && cnt == LAST_WORD));
        if (cs_n_s)                                pin = 1'b1;
        else if (st == ST_RD || st == ST_CRD_XFER) pin = dout_q;
        else                                       pin = rdy_n;
    end

    // chip-select release drops any transfer (R7)
    assert_cs_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (st == ST_CMD || st == ST_CRD_WAIT));

    // bit counter never exceeds a data word (R3)
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_WORD);

    // a word is consumed once per end of transfer (R9)
    assert_consume_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> !consume);

    // continuous-read shift only begins when a result is ready (R8)
    assert_xfer_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CRD_WAIT && st_n == ST_CRD_XFER) |-> !rdy_n);

endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port #(
    parameter int DATA_W      = 24,
    parameter int REG_W       = 8,
    parameter int GPO_N       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    output logic              dout_rdy,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    output logic [GPO_N-1:0]  gpo,
    output logic [REG_W-1:0]  mode_cfg
);
    logic              cs_n_s, din_s, sclk_rise, sclk_fall;
    logic [2:0]        rd_addr, wr_addr;
    logic              wr_en, busy, consume, rdy_n;
    logic [REG_W-1:0]  wr_data;
    logic [DATA_W-1:0] rd_value;

    cspi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .cs_n_s(cs_n_s), .din_s(din_s), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
    );

    cspi_fsm #(.DATA_W(DATA_W), .REG_W(REG_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .din_s(din_s),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .rd_value(rd_value),
        .rdy_n(rdy_n), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .consume(consume), .pin(dout_rdy)
    );

    cspi_regs #(.DATA_W(DATA_W), .REG_W(REG_W), .GPO_N(GPO_N)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .busy(busy), .consume(consume),
        .res_valid(res_valid), .res_data(res_data), .rd_value(rd_value),
        .rdy_n(rdy_n), .gpo(gpo), .mode_q(mode_cfg)
    );

endmodule

// File: tb/tb_conv_serial_port.sv
module tb_conv_serial_port;
    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        res_valid = 1'b0;
    logic [23:0] res_data = '0;
    wire         dout_rdy;
    wire  [3:0]  gpo;
    wire  [7:0]  mode_cfg;

    int checks = 0;
    int fails = 0;
    int cs_hi = 0;
    logic [7:0] m_gpio = 8'h00;

    always #5 clk = ~clk;

    conv_serial_port dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .dout_rdy(dout_rdy), .res_valid(res_valid), .res_data(res_data),
        .gpo(gpo), .mode_cfg(mode_cfg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the bench model while the port is deselected
    always @(negedge clk) begin
        if (cs_n) cs_hi++;
        else      cs_hi = 0;
        if (rst_n && cs_hi > 5) begin
            check("R7 pin high while deselected", {31'b0, dout_rdy}, 32'd1);
            check("R5 gpo follows model", {28'b0, gpo}, {28'b0, m_gpio[3:0]});
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift(input int n, input logic [31:0] tx, output logic [31:0] rx);
        rx = '0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            sclk = 1'b0;
            din  = tx[i];
            wait_clk(H);
            rx   = {rx[30:0], dout_rdy};
            sclk = 1'b1;
            wait_clk(H);
        end
    endtask

    task automatic conv(input logic [23:0] v);
        @(negedge clk);
        res_valid = 1'b1;
        res_data  = v;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic desel();
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    initial begin
        logic [31:0] r, r1, r2;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // reset state
        check("R2 reset pin", {31'b0, dout_rdy}, 32'd1);
        check("R5 reset gpo", {28'b0, gpo}, 32'd0);
        check("R5 reset mode", {24'b0, mode_cfg}, 32'd0);

        // status read with nothing ready
        sel();
        check("R2 pin shows not ready", {31'b0, dout_rdy}, 32'd1);
        shift(8, 32'h40, r); shift(8, 32'h0, r);
        check("R1 status not ready", r & 32'hFF, 32'h80);
        desel();

        // result arrives, read it twice
        conv(24'hA5C31E);
        sel();
        check("R2 pin low on ready", {31'b0, dout_rdy}, 32'd0);
        shift(8, 32'h40, r); shift(8, 32'h0, r);
        check("R2 status ready bit", r & 32'hFF, 32'h00);
        shift(8, 32'h58, r); shift(24, 32'h0, r);
        check("R3 data word MSB first", r & 32'hFFFFFF, 32'hA5C31E);
        wait_clk(4);
        check("R4 pin high after read", {31'b0, dout_rdy}, 32'd1);
        shift(8, 32'h58, r); shift(24, 32'h0, r);
        check("R4 reread same word", r & 32'hFFFFFF, 32'hA5C31E);
        desel();

        // mode and gpio writes
        sel();
        shift(8, 32'h08, r); shift(8, 32'h3B, r);
        shift(8, 32'h48, r); shift(8, 32'h0, r);
        check("R5 mode readback", r & 32'hFF, 32'h3B);
        check("R5 mode output", {24'b0, mode_cfg}, 32'h3B);
        shift(8, 32'h28, r); shift(8, 32'hA6, r);
        m_gpio = 8'hA6;
        shift(8, 32'h68, r); shift(8, 32'h0, r);
        check("R5 gpio readback", r & 32'hFF, 32'hA6);
        check("R5 gpo pins", {28'b0, gpo}, 32'h6);
        desel();

        // command byte with bit 7 set is ignored
        sel();
        shift(8, 32'hA8, r);
        shift(8, 32'h68, r); shift(8, 32'h0, r);
        check("R1 byte with bit7 ignored", r & 32'hFF, 32'hA6);
        desel();

        // abort mid-frame then realign
        sel();
        shift(3, 32'h2, r);
        desel();
        sel();
        shift(8, 32'h48, r); shift(8, 32'h0, r);
        check("R7 frame realigned after abort", r & 32'hFF, 32'h3B);
        desel();

        // result arrives during a data shift
        conv(24'h111111);
        sel();
        shift(8, 32'h58, r);
        shift(10, 32'h0, r1);
        conv(24'h222222);
        shift(14, 32'h0, r2);
        check("R6 word in flight unchanged", {r1[9:0], r2[13:0]}, 32'h111111);
        wait_clk(2 * H);
        check("R6 ready after deferred load", {31'b0, dout_rdy}, 32'd0);
        shift(8, 32'h58, r); shift(24, 32'h0, r);
        check("R6 deferred word", r & 32'hFFFFFF, 32'h222222);
        desel();

        // continuous read
        sel();
        shift(8, 32'h5C, r);
        wait_clk(4);
        check("R9 pin high before result", {31'b0, dout_rdy}, 32'd1);
        conv(24'h0F0F0F);
        wait_clk(4);
        check("R8 ready in continuous read", {31'b0, dout_rdy}, 32'd0);
        shift(24, 32'h0, r);
        check("R8 word without command", r & 32'hFFFFFF, 32'h0F0F0F);
        wait_clk(4);
        check("R9 pin high after read", {31'b0, dout_rdy}, 32'd1);
        shift(24, 32'h0, r);
        check("R9 no second read", r & 32'hFFFFFF, 32'hFFFFFF);
        conv(24'hC0FFEE);
        wait_clk(4);
        shift(24, 32'h0, r);
        check("R8 next word", r & 32'hFFFFFF, 32'hC0FFEE);
        shift(8, 32'h58, r);
        shift(8, 32'h40, r); shift(8, 32'h0, r);
        check("R10 command decoded after exit", r & 32'hFF, 32'h80);
        shift(8, 32'h58, r); shift(24, 32'h0, r);
        check("R10 normal data read after exit", r & 32'hFFFFFF, 32'hC0FFEE);
        desel();

        // 3-wire use: select held low throughout
        cs_n = 1'b0;
        wait_clk(4);
        shift(8, 32'h28, r); shift(8, 32'h5D, r);
        m_gpio = 8'h5D;
        shift(8, 32'h68, r); shift(8, 32'h0, r);
        check("R11 gpio readback 3-wire", r & 32'hFF, 32'h5D);
        check("R11 gpo 3-wire", {28'b0, gpo}, 32'hD);
        conv(24'h654321);
        wait_clk(4);
        check("R11 ready 3-wire", {31'b0, dout_rdy}, 32'd0);
        shift(8, 32'h58, r); shift(24, 32'h0, r);
        check("R11 data 3-wire", r & 32'hFFFFFF, 32'h654321);
        desel();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule